// File: doc/BRIEF.md
# Time-Slot Frame Receiver and Decoder

This block sits on the receive side of a serial digital interface that carries line-transmit data. One data bit arrives per clock. The stream is cut into repeating frames, and each frame holds eight data time slots followed by a 24-bit synchronisation word. The block tracks the current frame position and collects the fields of each slot. When a slot has fully arrived, the block presents the slot index, a decoded four-level symbol, five control flags and a framing status, all qualified by a one-cycle valid strobe.

The block supports two frame geometries, selected by `mode_i`:

- **Quaternary format** (`mode_i = 0`): slots of 21 bits, in a 192-bit frame.
- **Ternary format** (`mode_i = 1`): slots of 13 bits, in a 128-bit frame.

The start of slot 0 is marked by an external frame-sync pulse. Between pulses the position counter runs freely and wraps at the frame length. The content of the synchronisation word is not interpreted. Mode changes are expected only at a frame boundary that carries a sync pulse.

Top module: `tsf_rx`

## Requirements
- R1: With `mode_i = 0`, a frame is 192 bits long. Slots 0 to 7 occupy 21 bits each, starting at frame bits 0, 21, …, 147. Frame bits 168 to 191 form the synchronisation word. `valid_o` pulses once for each slot, and `slot_o` carries that slot's index.
- R2: With `mode_i = 1`, a frame is 128 bits long. Slots of 13 bits start at multiples of 13. Frame bits 104 to 127 form the synchronisation word.
- R3: The bit sampled while `fsync_i` is 1 is frame bit 0 (slot 0, slot bit 0), wherever the counter stood. Without a pulse, the counter wraps from the last frame bit to bit 0 and keeps decoding.
- R4: Slot bits 1, 2 and 3 are the symbol bits. Bit 1 is the top bit of the symbol field and bit 3 is the bottom bit.
- R5: `sym_o` is a 3-bit two's-complement level.
  - A symbol field with its top bit set gives 0 (000), whatever the lower two bits are.
  - Otherwise the mapping is: 000 → −3 (101), 001 → −1 (111), 010 → +3 (011), 011 → +1 (001).
- R6: Slot bits 4 to 8 appear on `flags_o[0]` to `flags_o[4]`. In order, these are the no-payload flag, power-down, loopback, range and terminal-side flags.
- R7: `sync_err_o` is 1 together with a slot's valid pulse exactly when that slot's bit 0 was 0. It changes only on a valid pulse.
- R8: All slot bits after bit 8 are reserved. If any reserved bit of a slot is 1, `resv_warn_o` goes to 1 in the cycle of that slot's valid pulse. It then stays at 1 until reset.
- R9: The bits of the synchronisation word raise no valid pulse and leave all slot outputs unchanged.
- R10: A synchronous active-high `rst_i` has the following effects:
  - It returns the position to frame bit 0.
  - It clears `valid_o`, `sync_err_o`, `resv_warn_o` and the slot outputs.
- R11: `valid_o` is high for exactly one cycle. That cycle is the one following the clock edge that samples the slot's last bit. The slot fields stay unchanged until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one data bit per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Frame geometry: 0 = 21-bit slots, 1 = 13-bit slots |
| fsync_i | input | 1 | Marks the current bit as frame bit 0 |
| sdx_i | input | 1 | Serial transmit-data bit |
| valid_o | output | 1 | One-cycle strobe for a completed slot |
| slot_o | output | 3 | Index of the completed slot |
| sym_o | output | 3 | Decoded symbol level, two's complement |
| flags_o | output | 5 | Slot control flags |
| sync_err_o | output | 1 | Slot sync bit was 0 |
| resv_warn_o | output | 1 | Sticky: a reserved bit was seen as 1 |

## Verification
Every slot result reaches the ports through a single register stage. The outputs for a slot are therefore due in the cycle after the rising edge that samples the slot's last bit.

The bench drives each bit at a falling edge and waits through the following rising edge. It then reads the ports at the next falling edge. At that point `valid_o` must be 1 for a slot's final bit and 0 for every other bit.

The sticky warning is compared after every slot. The held slot fields are compared once more at the end of each synchronisation word.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int TD_W      = 3;
    localparam int NUM_FLAGS = 5;
    localparam int LEVEL_W   = 3;

    typedef enum logic {
        FMT_Q21 = 1'b0,
        FMT_T13 = 1'b1
    } fmt_e;

    typedef logic [TD_W-1:0]      td_t;
    typedef logic [NUM_FLAGS-1:0] flags_t;
    typedef logic [LEVEL_W-1:0]   level_t;

endpackage

// File: rtl/tsf_frame_pos.sv
module tsf_frame_pos #(
    parameter int SLOT_LEN_Q = 21,
    parameter int SLOT_LEN_T = 13,
    parameter int SYNC_LEN   = 24,
    parameter int NUM_SLOTS  = 8,
    parameter int BIT_W      = 5,
    parameter int SLOT_W     = 4,
    parameter int IDX_W      = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  tsf_pkg::fmt_e     fmt_i,
    input  logic              fsync_i,
    output logic [BIT_W-1:0]  cur_bit_o,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              in_data_o,
    output logic              last_data_o
);

    typedef struct packed {
        logic [BIT_W-1:0]  bit_idx;
        logic [SLOT_W-1:0] seg;
    } pos_t;

    pos_t pos_q, pos_d, cur;
    logic [BIT_W-1:0] slot_len;
    logic [BIT_W-1:0] seg_len;
    logic             in_sync;
    logic             at_end;

    always_comb begin
        cur      = fsync_i ? '0 : pos_q;
        slot_len = (fmt_i == tsf_pkg::FMT_T13) ? BIT_W'(SLOT_LEN_T) : BIT_W'(SLOT_LEN_Q);
        in_sync  = (cur.seg >= SLOT_W'(NUM_SLOTS));
        seg_len  = in_sync ? BIT_W'(SYNC_LEN) : slot_len;
        at_end   = (cur.bit_idx >= (seg_len - BIT_W'(1)));

        pos_d = cur;
        if (at_end) begin
            pos_d.bit_idx = '0;
            pos_d.seg     = in_sync ? '0 : (cur.seg + SLOT_W'(1));
        end else begin
            pos_d.bit_idx = cur.bit_idx + BIT_W'(1);
        end

        cur_bit_o   = cur.bit_idx;
        cur_idx_o   = cur.seg[IDX_W-1:0];
        in_data_o   = !in_sync;
        last_data_o = !in_sync && at_end;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/tsf_slot_capture.sv
module tsf_slot_capture #(
    parameter int BIT_W = 5,
    parameter int IDX_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sdx_i,
    input  logic [BIT_W-1:0]   cur_bit_i,
    input  logic [IDX_W-1:0]   cur_idx_i,
    input  logic               in_data_i,
    input  logic               last_data_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   slot_o,
    output tsf_pkg::td_t       td_o,
    output tsf_pkg::flags_t    flags_o,
    output logic               sync_err_o,
    output logic               resv_warn_o
);

    localparam int TD_W    = tsf_pkg::TD_W;
    localparam int NFLG    = tsf_pkg::NUM_FLAGS;
    localparam int FLAG_LO = 1 + TD_W;
    localparam int RSV_LO  = FLAG_LO + NFLG;

    typedef struct packed {
        logic            sync_ok;
        tsf_pkg::td_t    td;
        tsf_pkg::flags_t flags;
        logic            resv;
    } acc_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] slot;
        tsf_pkg::td_t     td;
        tsf_pkg::flags_t  flags;
        logic             err;
        logic             warn;
    } out_t;

    acc_t acc_q, acc_d;
    out_t out_q, out_d;

    always_comb begin
        acc_d = acc_q;
        if (in_data_i) begin
            if (cur_bit_i == '0) begin
                acc_d.sync_ok = sdx_i;
                acc_d.td      = '0;
                acc_d.flags   = '0;
                acc_d.resv    = 1'b0;
            end else if (cur_bit_i < BIT_W'(FLAG_LO)) begin
                for (int i = 0; i < TD_W; i++) begin
                    if (cur_bit_i == BIT_W'(i + 1)) begin
                        acc_d.td[TD_W-1-i] = sdx_i;
                    end
                end
            end else if (cur_bit_i < BIT_W'(RSV_LO)) begin
                for (int i = 0; i < NFLG; i++) begin
                    if (cur_bit_i == BIT_W'(FLAG_LO + i)) begin
                        acc_d.flags[i] = sdx_i;
                    end
                end
            end else begin
                acc_d.resv = acc_q.resv | sdx_i;
            end
        end

        out_d       = out_q;
        out_d.valid = last_data_i;
        if (last_data_i) begin
            out_d.slot  = cur_idx_i;
            out_d.td    = acc_d.td;
            out_d.flags = acc_d.flags;
            out_d.err   = !acc_d.sync_ok;
            out_d.warn  = out_q.warn | acc_d.resv;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
            out_q <= '0;
        end else begin
            acc_q <= acc_d;
            out_q <= out_d;
        end
    end

    assign valid_o     = out_q.valid;
    assign slot_o      = out_q.slot;
    assign td_o        = out_q.td;
    assign flags_o     = out_q.flags;
    assign sync_err_o  = out_q.err;
    assign resv_warn_o = out_q.warn;

endmodule

// File: rtl/tsf_level_map.sv
module tsf_level_map (
    input  tsf_pkg::td_t    td_i,
    output tsf_pkg::level_t level_o
);

    always_comb begin
        if (td_i[2]) begin
            level_o = 3'b000;
        end else begin
            unique case (td_i[1:0])
                2'b00:   level_o = 3'b101;
                2'b01:   level_o = 3'b111;
                2'b10:   level_o = 3'b011;
                default: level_o = 3'b001;
            endcase
        end
    end

endmodule

// File: rtl/tsf_rx.sv
module tsf_rx #(
    parameter int SLOT_LEN_Q = 21,
    parameter int SLOT_LEN_T = 13,
    parameter int SYNC_LEN   = 24,
    parameter int NUM_SLOTS  = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         mode_i,
    input  logic                         fsync_i,
    input  logic                         sdx_i,
    output logic                         valid_o,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_o,
    output logic [2:0]                   sym_o,
    output logic [4:0]                   flags_o,
    output logic                         sync_err_o,
    output logic                         resv_warn_o
);

    localparam int MAX_SEG = (SYNC_LEN > SLOT_LEN_Q) ?
                             ((SYNC_LEN > SLOT_LEN_T) ? SYNC_LEN : SLOT_LEN_T) :
                             ((SLOT_LEN_Q > SLOT_LEN_T) ? SLOT_LEN_Q : SLOT_LEN_T);
    localparam int BIT_W   = $clog2(MAX_SEG + 1);
    localparam int SLOT_W  = $clog2(NUM_SLOTS + 1);
    localparam int IDX_W   = $clog2(NUM_SLOTS);

    logic [BIT_W-1:0] cur_bit;
    logic [IDX_W-1:0] cur_idx;
    logic             in_data;
    logic             last_data;
    tsf_pkg::td_t     td_q;
    tsf_pkg::fmt_e    fmt;

    assign fmt = tsf_pkg::fmt_e'(mode_i);

    tsf_frame_pos #(
        .SLOT_LEN_Q (SLOT_LEN_Q),
        .SLOT_LEN_T (SLOT_LEN_T),
        .SYNC_LEN   (SYNC_LEN),
        .NUM_SLOTS  (NUM_SLOTS),
        .BIT_W      (BIT_W),
        .SLOT_W     (SLOT_W),
        .IDX_W      (IDX_W)
    ) u_pos (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .fmt_i       (fmt),
        .fsync_i     (fsync_i),
        .cur_bit_o   (cur_bit),
        .cur_idx_o   (cur_idx),
        .in_data_o   (in_data),
        .last_data_o (last_data)
    );

    tsf_slot_capture #(
        .BIT_W (BIT_W),
        .IDX_W (IDX_W)
    ) u_cap (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sdx_i       (sdx_i),
        .cur_bit_i   (cur_bit),
        .cur_idx_i   (cur_idx),
        .in_data_i   (in_data),
        .last_data_i (last_data),
        .valid_o     (valid_o),
        .slot_o      (slot_o),
        .td_o        (td_q),
        .flags_o     (flags_o),
        .sync_err_o  (sync_err_o),
        .resv_warn_o (resv_warn_o)
    );

    tsf_level_map u_map (
        .td_i    (td_q),
        .level_o (sym_o)
    );

endmodule

// File: rtl/tsf_rx_chk.sv
module tsf_rx_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       fsync_i,
    input logic       valid_o,
    input logic [2:0] sym_o,
    input logic       sync_err_o,
    input logic       resv_warn_o
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o); // R11

    AST_WARN_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        resv_warn_o |=> resv_warn_o); // R8

    AST_LEVEL_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (sym_o != 3'b100 && (sym_o[0] || sym_o == 3'b000))); // R5

    AST_FSYNC_NO_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        fsync_i |=> !valid_o); // R3

    AST_ERR_ONLY_ON_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> $stable(sync_err_o)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!valid_o && !resv_warn_o && !sync_err_o)); // R10

endmodule

bind tsf_rx tsf_rx_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fsync_i     (fsync_i),
    .valid_o     (valid_o),
    .sym_o       (sym_o),
    .sync_err_o  (sync_err_o),
    .resv_warn_o (resv_warn_o)
);

// File: tb/tsf_rx_tb_top.sv
module tsf_rx_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       mode_i = 1'b0;
    logic       fsync_i = 1'b0;
    logic       sdx_i = 1'b0;
    logic       valid_o;
    logic [2:0] slot_o;
    logic [2:0] sym_o;
    logic [4:0] flags_o;
    logic       sync_err_o;
    logic       resv_warn_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  warn_exp = 1'b0;

    logic        sb [8];
    logic [2:0]  td [8];
    logic [4:0]  fl [8];
    logic [11:0] rv [8];

    always #2 clk_i = ~clk_i;

    tsf_rx dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_i      (mode_i),
        .fsync_i     (fsync_i),
        .sdx_i       (sdx_i),
        .valid_o     (valid_o),
        .slot_o      (slot_o),
        .sym_o       (sym_o),
        .flags_o     (flags_o),
        .sync_err_o  (sync_err_o),
        .resv_warn_o (resv_warn_o)
    );

    function automatic logic [2:0] exp_level(input logic [2:0] t);
        if (t[2]) return 3'b000;
        case (t[1:0])
            2'b00:   return 3'b101;
            2'b01:   return 3'b111;
            2'b10:   return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic slot_bit(input int s, input int b);
        if (b == 0) return sb[s];
        if (b <= 3) return td[s][3-b];
        if (b <= 8) return fl[s][b-4];
        return rv[s][b-9];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input logic fs);
        sdx_i   = b;
        fsync_i = fs;
        @(posedge clk_i);
        @(negedge clk_i);
        fsync_i = 1'b0;
    endtask

    task automatic fill_random(input bit allow_err, input bit allow_resv, input int slen);
        for (int s = 0; s < 8; s++) begin
            sb[s] = allow_err ? (($urandom % 5) != 0) : 1'b1;
            td[s] = 3'($urandom);
            fl[s] = 5'($urandom);
            if (allow_resv && (($urandom % 4) == 0))
                rv[s] = 12'($urandom) & 12'((1 << (slen - 9)) - 1);
            else
                rv[s] = '0;
        end
    endtask

    task automatic send_frame(input logic fmt, input bit use_fs, input string req);
        int slen;
        mode_i = fmt;
        slen = fmt ? 13 : 21;
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < slen; b++) begin
                drive_bit(slot_bit(s, b), use_fs && s == 0 && b == 0);
                if (b == slen - 1) begin
                    check(valid_o === 1'b1, req, "valid at slot end", int'(valid_o), 1);
                    check(slot_o === 3'(s), "R1", "slot index", int'(slot_o), s);
                    check(sym_o === exp_level(td[s]), "R5", "symbol level (R4 bits)",
                          int'(sym_o), int'(exp_level(td[s])));
                    check(flags_o === fl[s], "R6", "flags", int'(flags_o), int'(fl[s]));
                    check(sync_err_o === !sb[s], "R7", "sync error", int'(sync_err_o), int'(!sb[s]));
                    if (rv[s] != 0) warn_exp = 1'b1;
                    check(resv_warn_o === warn_exp, "R8", "reserved warning",
                          int'(resv_warn_o), int'(warn_exp));
                end else begin
                    check(valid_o === 1'b0, "R11", "no valid mid-slot", int'(valid_o), 0);
                end
            end
        end
        for (int b = 0; b < 24; b++) begin
            drive_bit(1'($urandom), 1'b0);
            check(valid_o === 1'b0, "R9", "no valid in sync word", int'(valid_o), 0);
        end
        check(slot_o === 3'd7 && sym_o === exp_level(td[7]) && flags_o === fl[7],
              "R9", "slot fields held over sync word", int'(flags_o), int'(fl[7]));
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check(valid_o === 1'b0 && sync_err_o === 1'b0 && resv_warn_o === 1'b0 &&
              slot_o === 3'd0 && flags_o === 5'd0, "R10", "outputs cleared",
              int'({valid_o, sync_err_o, resv_warn_o, flags_o}), 0);
        rst_i = 1'b0;
        warn_exp = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R4 / R5: every symbol code once, clean slots, warning stays clear
        for (int s = 0; s < 8; s++) begin
            sb[s] = 1'b1; td[s] = 3'(s); fl[s] = 5'(1 << (s % 5)); rv[s] = '0;
        end
        send_frame(1'b0, 1'b1, "R1");

        // R3: free-running wrap without a sync pulse
        fill_random(1'b1, 1'b0, 21);
        send_frame(1'b0, 1'b0, "R3");

        // R3: realign after stray bits
        for (int i = 0; i < 7; i++) begin
            drive_bit(1'($urandom), 1'b0);
            check(valid_o === 1'b0, "R3", "no valid in stray bits", int'(valid_o), 0);
        end
        fill_random(1'b1, 1'b0, 21);
        send_frame(1'b0, 1'b1, "R3");

        // R8: reserved bit set in one slot
        fill_random(1'b0, 1'b0, 21);
        rv[2] = 12'h800;
        send_frame(1'b0, 1'b1, "R8");

        // R2: ternary-format frames
        for (int f = 0; f < 6; f++) begin
            fill_random(1'b1, 1'b1, 13);
            send_frame(1'b1, f == 0, "R2");
        end

        // R10: reset mid-frame, then decode without a pulse
        mode_i = 1'b0;
        for (int i = 0; i < 30; i++) drive_bit(1'($urandom), i == 0);
        do_reset();
        fill_random(1'b1, 1'b0, 21);
        send_frame(1'b0, 1'b0, "R10");

        // mixed random frames in both formats
        for (int f = 0; f < 12; f++) begin
            logic m;
            m = 1'($urandom);
            fill_random(1'b1, 1'b1, m ? 13 : 21);
            send_frame(m, 1'b1, m ? "R2" : "R1");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule